// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Target

This block is the target side of a two-wire serial bus (I2C) for a bank of four byte-wide registers. It watches the already-synchronized clock and data lines and drives a single open-drain pull-low enable for the data line. It recognizes START, repeated START and STOP conditions and answers only to one fixed 7-bit address. In a write, the first byte after the address is a command byte whose low bits become a persistent register pointer. Every later byte of that write is stored into the register the pointer names. A read transfer returns the register the pointer names.

The pointer never advances on its own. Any number of write bytes land in the same register, and any number of read bytes come from the same register, each one sampled fresh from the bank. The pointer survives STOP and repeated START, so a master that has set it once can keep polling one register with short read transfers. The register storage lives outside the block, behind a simple port: a select, a one-cycle write strobe with data, and a one-cycle read strobe with combinational read data.

The controller is one enumerated state machine. IDLE waits for START. ADDR shifts in the address byte and goes to ADDR_ACK on a match or to IGNORE on a mismatch. ADDR_ACK goes to CMD for a write or to RDATA for a read. CMD goes to CMD_ACK, and CMD_ACK goes to WDATA. WDATA goes to WDATA_ACK, which returns to WDATA. RDATA goes to RACK. RACK returns to RDATA on a master ACK and goes to IGNORE on a NACK. From any state, START leads to ADDR and STOP leads to IDLE.

Top module: `ptr_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal the parameter TGT_ADDR (default 7'b1000001) is acknowledged by pulling SDA low for the ninth clock. Bit 0 of the address byte selects the direction, 0 for write and 1 for read. Any other address gets no acknowledge, and the block stays silent for the rest of that transfer: no register strobes and no SDA drive.
- R2: In a write, the first byte after the address is the command byte and it is acknowledged. Its bits [1:0] become the register pointer, driven on reg_sel_o. Bits [7:2] are ignored.
- R3: Each byte after the command byte in the same write is acknowledged and produces exactly one reg_wr_o pulse to the register the pointer names. The pointer does not auto-increment.
- R4: In a read, the addressed register is sent MSB first. SDA changes only while SCL is low.
- R5: Each read byte is sampled from the bank when it is loaded, with one reg_rd_o pulse per byte. A master ACK is followed by another byte from the same register. A master NACK releases SDA until the next START or STOP.
- R6: The pointer keeps its value across STOP and repeated START. A later read transfer returns the last commanded register.
- R7: A START or STOP at any point abandons the byte in progress without any register write. START returns the block to address reception, and STOP returns it to idle.
- R8: Reset clears the pointer to 0, releases SDA and puts the state machine in idle.
- R9: There is no minimum SCL rate. Transfers with long clock phases behave the same as fast ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line, as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_sel_o | output | PTR_W | Register pointer and bank select |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rd_o | output | 1 | One-cycle strobe when a read byte is sampled |
| reg_rdata_i | input | 8 | Bank data for the selected register |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- Command bytes with the upper bits set. A design that used the whole byte would select the wrong register.
- Several data bytes in one write. A design that auto-incremented would spread them over neighbouring registers.
- Multi-byte reads from a bank that changes its value after every sample. Stale data would come back unchanged.
- STARTs and STOPs injected mid-byte. A design that does not abort would issue a spurious write, or misread the next address.
- A wrong address and a reset mid-use. These expose a design that answers strangers or keeps a stale pointer.
- Very slow clock phases. A design that depends on timing would fail here.

// File: rtl/ptrt_pkg.sv
package ptrt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/ptrt_line_mon.sv
module ptrt_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // data edges while clock stays high are bus conditions
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/ptrt_shifter.sv
module ptrt_shifter #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic          sample,
    input  logic          shift_out,
    input  logic          bit_i,
    input  logic [W-1:0]  load_val,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (load) begin
            data_o <= load_val;
            cnt_o  <= '0;
        end else if (sample) begin
            data_o <= {data_o[W-2:0], bit_i};
            cnt_o  <= cnt_o + 1'b1;
        end else if (shift_out) begin
            data_o <= {data_o[W-2:0], 1'b1};
            cnt_o  <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/ptr_i2c_target.sv
module ptr_i2c_target
    import ptrt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'b1000001,
    parameter int         REG_NUM  = 4,
    localparam int        PTR_W    = $clog2(REG_NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [PTR_W-1:0]  reg_sel_o,
    output logic              reg_wr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              reg_rd_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e state;
    tgt_state_e nxt;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic sh_clr, sh_load, sh_sample, sh_shift;
    logic [BYTE_W-1:0] sh_data;
    logic [CNT_W-1:0]  sh_cnt;
    logic byte_in_done;
    logic addr_hit;
    logic rw_q;
    logic mack_q;
    logic [PTR_W-1:0] ptr_q;

    ptrt_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    ptrt_shifter #(.W(BYTE_W), .CW(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .load     (sh_load),
        .sample   (sh_sample),
        .shift_out(sh_shift),
        .bit_i    (sda_i),
        .load_val (reg_rdata_i),
        .data_o   (sh_data),
        .cnt_o    (sh_cnt)
    );

    assign byte_in_done = scl_fall && (sh_cnt == CNT_FULL);
    assign addr_hit     = (sh_data[BYTE_W-1:1] == TGT_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_in_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_in_done) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_in_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && sh_cnt == CNT_LAST) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // direction, master acknowledge and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if (state == ST_ADDR && byte_in_done) rw_q <= sh_data[0];
            if (state == ST_RACK && scl_rise)     mack_q <= ~sda_i;
            if (state == ST_CMD && byte_in_done && !start_det && !stop_det)
                ptr_q <= sh_data[PTR_W-1:0];
        end
    end

    // outputs and datapath controls
    always_comb begin
        sda_pull_o = 1'b0;
        reg_wr_o   = 1'b0;
        reg_rd_o   = 1'b0;
        sh_clr     = start_det;
        sh_load    = 1'b0;
        sh_sample  = 1'b0;
        sh_shift   = 1'b0;
        unique case (state)
            ST_IDLE, ST_IGNORE: ;
            ST_ADDR, ST_CMD: begin
                sh_sample = scl_rise && (sh_cnt < CNT_FULL);
            end
            ST_WDATA: begin
                sh_sample = scl_rise && (sh_cnt < CNT_FULL);
                reg_wr_o  = byte_in_done && !stop_det && !start_det;
            end
            ST_ADDR_ACK: begin
                sda_pull_o = 1'b1;
                if (scl_fall) begin
                    sh_load  = rw_q;
                    reg_rd_o = rw_q;
                    sh_clr   = sh_clr | ~rw_q;
                end
            end
            ST_CMD_ACK, ST_WDATA_ACK: begin
                sda_pull_o = 1'b1;
                sh_clr     = sh_clr | scl_fall;
            end
            ST_RDATA: begin
                sda_pull_o = ~sh_data[BYTE_W-1];
                sh_shift   = scl_fall && (sh_cnt < CNT_LAST);
            end
            ST_RACK: begin
                sh_load  = scl_fall && mack_q;
                reg_rd_o = scl_fall && mack_q;
            end
            default: ;
        endcase
    end

    assign reg_sel_o   = ptr_q;
    assign reg_wdata_o = sh_data;

endmodule

// File: rtl/ptrt_checker.sv
module ptrt_checker
    import ptrt_pkg::*;
#(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_pull_o,
    input logic [PTR_W-1:0] reg_sel_o,
    input logic             reg_wr_o,
    input logic             reg_rd_o,
    input tgt_state_e       state
);

    // R4: the driven data never moves while the clock is high
    p_pull_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

    // R3: a byte is written only at the clock fall closing its eighth bit
    p_wr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (!scl_i && $past(scl_i)));

    // R5: read data is sampled only at a clock fall
    p_rd_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |-> (!scl_i && $past(scl_i)));

    // R3: a write and a read sample never coincide
    p_wr_rd_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));

    // R6: the pointer only moves on completion of a command byte
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_sel_o) |-> ($past(state) == ST_CMD));

endmodule

bind ptr_i2c_target ptrt_checker #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_pull_o(sda_pull_o),
    .reg_sel_o (reg_sel_o),
    .reg_wr_o  (reg_wr_o),
    .reg_rd_o  (reg_rd_o),
    .state     (state)
);

// File: tb/ptr_i2c_target_tb_top.sv
`timescale 1ns/1ps
module ptr_i2c_target_tb_top;

    localparam logic [6:0] TA = 7'b1000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [1:0] sel;
    logic wr, rd;
    logic [7:0] wdata, rdata;

    logic [7:0] bank [4];
    logic [7:0] exp_regs [4];
    logic [1:0] exp_ptr;
    bit bump = 1'b0;
    int wr_cnt = 0, rd_cnt = 0;
    int checks = 0, errors = 0;
    int hp = 8;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rdata = bank[sel];

    ptr_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .reg_sel_o(sel), .reg_wr_o(wr),
        .reg_wdata_o(wdata), .reg_rd_o(rd), .reg_rdata_i(rdata)
    );

    // register bank model
    always @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= 8'h11; bank[1] <= 8'h22; bank[2] <= 8'h33; bank[3] <= 8'h44;
        end else begin
            if (wr) begin bank[sel] <= wdata; wr_cnt <= wr_cnt + 1; end
            else if (rd && bump) bank[sel] <= bank[sel] + 8'd1;
            if (rd) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        sda_m = 1'b1; wt(hp); scl = 1'b1; wt(hp); sda_m = 1'b0; wt(hp); scl = 1'b0; wt(hp);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; wt(hp); scl = 1'b1; wt(hp); sda_m = 1'b1; wt(hp);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i]; wt(hp); scl = 1'b1; wt(hp); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(hp); scl = 1'b1; wt(hp / 2);
        ack = !sda_line;
        wt(hp - hp / 2); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b, output bit unst);
        logic s0;
        sda_m = 1'b1; unst = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(hp); scl = 1'b1; wt(1); s0 = sda_line; wt(hp - 1);
            if (sda_line !== s0) unst = 1'b1;
            b[i] = s0; scl = 1'b0;
        end
        sda_m = !mack; wt(hp); scl = 1'b1; wt(hp); scl = 1'b0; wt(1); sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            output bit aack, output int nacks);
        bit k;
        logic [7:0] d;
        b_start();
        send_byte({a, 1'b0}, k); aack = k; nacks = k ? 0 : 1;
        send_byte(cmd, k); if (!k) nacks++;
        for (int i = 0; i < n; i++) begin
            d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
            send_byte(d, k); if (!k) nacks++;
        end
        b_stop();
        if (a == TA) begin
            exp_ptr = cmd[1:0];
            if (n > 0) exp_regs[exp_ptr] = (n == 1) ? d0 : (n == 2) ? d1 : d2;
        end
    endtask

    task automatic do_read(input logic [6:0] a, input int n, output bit aack,
                           output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2,
                           output bit unst);
        logic [7:0] b;
        bit u;
        b_start();
        send_byte({a, 1'b1}, aack);
        unst = 1'b0; r0 = 8'h00; r1 = 8'h00; r2 = 8'h00;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b, u);
            if (u) unst = 1'b1;
            if (i == 0) r0 = b; else if (i == 1) r1 = b; else r2 = b;
        end
        b_stop();
    endtask

    function automatic logic [31:0] exp_bank4();
        return {exp_regs[3], exp_regs[2], exp_regs[1], exp_regs[0]};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; wt(4); rst_n = 1'b1; wt(2);
        exp_regs[0] = 8'h11; exp_regs[1] = 8'h22; exp_regs[2] = 8'h33; exp_regs[3] = 8'h44;
        exp_ptr = 2'd0;
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit aack, u;
        int nk, w0, r0c, op, n;
        logic [7:0] a0, a1, a2, c, d0, d1, d2;
        void'($urandom(32'd2024));
        do_reset();

        // R8: reset state
        chk("R8 sda released", {31'd0, sda_pull}, 32'd0);
        chk("R8 pointer zero", {30'd0, sel}, 32'd0);

        // R1 R2 R3: command with upper bits set, two data bytes
        w0 = wr_cnt;
        do_write(TA, 8'hFE, 2, 8'hA5, 8'h3C, 8'h00, aack, nk);
        chk("R1 address ack", {31'd0, aack}, 32'd1);
        chk("R3 all bytes acked", nk, 0);
        chk("R2 pointer low bits", {30'd0, sel}, 32'd2);
        chk("R3 one strobe per byte", wr_cnt - w0, 2);
        chk("R3 no auto-increment", {bank[3], bank[2], bank[1], bank[0]}, exp_bank4());

        // R4 R6: read after STOP uses retained pointer
        do_read(TA, 2, aack, a0, a1, a2, u);
        chk("R6 read retained ptr b0", a0, exp_regs[2]);
        chk("R6 read retained ptr b1", a1, exp_regs[2]);
        chk("R4 sda steady while scl high", {31'd0, u}, 32'd0);

        // R5: bank changes after each sample, bytes must follow
        bump = 1'b1; r0c = rd_cnt;
        do_read(TA, 3, aack, a0, a1, a2, u);
        bump = 1'b0;
        chk("R5 resample b0", a0, exp_regs[2]);
        chk("R5 resample b1", a1, exp_regs[2] + 8'd1);
        chk("R5 resample b2", a2, exp_regs[2] + 8'd2);
        chk("R5 one sample per byte", rd_cnt - r0c, 3);
        exp_regs[2] = exp_regs[2] + 8'd3;

        // R5: after NACK the block stays off the line
        b_start(); send_byte({TA, 1'b1}, aack); recv_byte(1'b0, a0, u);
        send_bits(8'h00, 8);
        chk("R5 released after nack", {31'd0, sda_pull}, 32'd0);
        b_stop();

        // R1: wrong address, write and read
        w0 = wr_cnt; r0c = rd_cnt;
        do_write(7'b1000010, 8'h03, 1, 8'h99, 8'h00, 8'h00, aack, nk);
        chk("R1 mismatch no ack", {31'd0, aack}, 32'd0);
        chk("R1 mismatch no strobes", wr_cnt - w0, 0);
        chk("R1 mismatch pointer kept", {30'd0, sel}, {30'd0, exp_ptr});
        do_read(7'b0000001, 1, aack, a0, a1, a2, u);
        chk("R1 mismatch read line idle", a0, 8'hFF);
        chk("R1 mismatch no read sample", rd_cnt - r0c, 0);

        // R6: pointer set then repeated START read
        b_start(); send_byte({TA, 1'b0}, aack); send_byte(8'h01, aack);
        exp_ptr = 2'd1;
        b_start(); send_byte({TA, 1'b1}, aack); recv_byte(1'b0, a0, u); b_stop();
        chk("R6 repeated start read", a0, exp_regs[1]);

        // R7: START in mid data byte abandons it
        w0 = wr_cnt;
        b_start(); send_byte({TA, 1'b0}, aack); send_byte(8'h03, aack);
        send_bits(8'hAA, 4);
        b_start(); send_byte({TA, 1'b0}, aack); send_byte(8'h00, aack); b_stop();
        exp_ptr = 2'd0;
        chk("R7 start aborts byte", wr_cnt - w0, 0);
        chk("R7 restart address accepted", {30'd0, sel}, 32'd0);
        // R7: STOP in mid data byte abandons it
        b_start(); send_byte({TA, 1'b0}, aack); send_byte(8'h02, aack);
        exp_ptr = 2'd2;
        send_bits(8'h55, 5); b_stop();
        chk("R7 stop aborts byte", wr_cnt - w0, 0);
        chk("R7 line released", {31'd0, sda_pull}, 32'd0);
        chk("R7 bank intact", {bank[3], bank[2], bank[1], bank[0]}, exp_bank4());

        // R8: reset clears the pointer
        do_reset();
        do_read(TA, 1, aack, a0, a1, a2, u);
        chk("R8 read after reset uses reg 0", a0, exp_regs[0]);

        // R9: very slow clock phases
        hp = 400;
        do_write(TA, 8'h03, 1, 8'h5A, 8'h00, 8'h00, aack, nk);
        chk("R9 slow write acked", nk, 0);
        do_read(TA, 1, aack, a0, a1, a2, u);
        chk("R9 slow read", a0, 8'h5A);

        // random traffic
        for (int it = 0; it < 16; it++) begin
            hp = $urandom_range(20, 4);
            op = $urandom_range(2, 0);
            c = 8'($urandom); d0 = 8'($urandom); d1 = 8'($urandom); d2 = 8'($urandom);
            n = $urandom_range(3, 0);
            if (op == 0) begin
                do_write(TA, c, n, d0, d1, d2, aack, nk);
                chk("R3 random write acks", nk, 0);
                chk("R2 random bank", {bank[3], bank[2], bank[1], bank[0]}, exp_bank4());
            end else if (op == 1) begin
                if (n == 0) n = 1;
                do_read(TA, n, aack, a0, a1, a2, u);
                chk("R4 random read b0", a0, exp_regs[exp_ptr]);
                if (n > 1) chk("R5 random read b1", a1, exp_regs[exp_ptr]);
                chk("R4 random steady", {31'd0, u}, 32'd0);
            end else begin
                w0 = wr_cnt;
                do_write({c[6:1], ~TA[0]}, d0, n, d1, d2, d0, aack, nk);
                chk("R1 random mismatch", wr_cnt - w0, 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule